// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Bus-Loaded Threshold Offsets

This block is a first-in first-out buffer for 9-bit words. The write side and the read side each run on their own clock. Storage depth is a power-of-two parameter. The block raises four status flags: empty, full, almost-empty and almost-full. The two thresholds behind the partial flags live in offset registers. These registers have no port of their own. They are written through the data input bus and read back through the data output bus.

A dual-purpose pin, `wr_en2_ld`, decides how the block behaves, and its level during reset picks the role. If it is high while reset is held, it acts as an active-high second write enable for the rest of operation, and the offset path is unused. If it is low while reset is held, the block enters load mode. In load mode, driving the pin low steers writes and reads to the offset registers in place of the storage array. Driving it high restores normal data transfers.

Offset bytes follow a fixed four-step rotation that wraps. The rotation has its own step counter on each side: one for loading, one for readback. Reset returns both counters to the first step.

Read and write pointers cross between the clock domains in Gray code through two-flop synchronizers. Full and almost-full are derived in the write domain. Empty and almost-empty are derived in the read domain. The offsets are configuration values. Software should change them only while no data is moving.

Top module: `sync_fifo9_pgm`

## Requirements
- R1: While `rst_n` is low and on the first cycles after release, the flags read empty=1, full=0, almost_empty=1, almost_full=0 and `dout` is 0. Reset discards all stored words.
- R2: A word on `din` is stored on a `wr_clk` edge where `wr_en1_n`=0 and `wr_en2_ld`=1 and the FIFO is not full. A word is presented on `dout` on a `rd_clk` edge where `rd_en1_n`=0 and `rd_en2_n`=0, the FIFO is not empty, and load is not asserted. Words come out in the order they were written.
- R3: `full` is 1 exactly when DEPTH words are held. A write attempted while full is dropped, and the stored words are unchanged.
- R4: A read attempted while empty is ignored, and `dout` keeps its previous value.
- R5: If `wr_en2_ld` is high during reset, the pin is an active-high write enable afterwards. With it low, `wr_en1_n`=0 stores nothing.
- R6: In load mode (pin low during reset), each `wr_clk` edge with `wr_en2_ld`=0 and `wr_en1_n`=0 takes `din[7:0]` into the next offset byte. The byte order is: almost-empty low, almost-empty high, almost-full low, almost-full high, then back to almost-empty low.
- R7: In load mode, each `rd_clk` edge with `wr_en2_ld`=0 and both read enables low puts the next offset byte on `dout[7:0]` with `dout[8]`=0. It uses the same four-step order, on its own step counter, which starts at almost-empty low after reset.
- R8: While load is asserted, no data word is written or read. The stored words and the flags are unchanged.
- R9: Both offsets are 7 after reset. `almost_empty` is 1 when the stored count is at or below the almost-empty offset. `almost_full` is 1 when DEPTH minus the count is at or below the almost-full offset.
- R10: Each offset keeps only log2(DEPTH) bits. High-byte bits above that width are dropped on load and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| din | input | 9 | Write data; bits 7:0 also carry offset bytes |
| wr_en1_n | input | 1 | Write enable 1, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or load control (active low), role chosen at reset |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| dout | output | 9 | Output register: data words or offset bytes |
| empty | output | 1 | No words held (read domain) |
| full | output | 1 | DEPTH words held (write domain) |
| almost_empty | output | 1 | Count at or below almost-empty offset (read domain) |
| almost_full | output | 1 | Free space at or below almost-full offset (write domain) |

## Verification
The bench builds the block with DEPTH=512. The offsets are then 9 bits wide, so exactly one high-byte bit is kept and seven are masked. That makes the masking rule visible at the readback bus. A 512-word fill stays short enough to drive the array to full, push past it, and walk both partial-flag boundaries one word at a time. Loading eight bytes in sequence exercises the rotation wrap, and random push and pop bursts on top of that exercise the flags against the small loaded thresholds.

// File: rtl/fifo9_pkg.sv
`timescale 1ns/1ps
// Shared types for the 9-bit dual-clock FIFO.
// Assumes: offset bytes follow a fixed four-step rotation.
package fifo9_pkg;
    localparam int WORD_W = 9;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        STEP_AE_LO = 2'd0,
        STEP_AE_HI = 2'd1,
        STEP_AF_LO = 2'd2,
        STEP_AF_HI = 2'd3
    } ofs_step_e;

    // Advance the rotation by one step, wrapping after the last.
    function automatic ofs_step_e next_step(input ofs_step_e s);
        logic [1:0] t;
        t = s + 2'd1;
        return ofs_step_e'(t);
    endfunction
endpackage

// File: rtl/fifo9_ram.sv
`timescale 1ns/1ps
// Storage array: one synchronous write port and one combinational read port.
// Assumes: the read side registers the output; storage contents have no reset.
module fifo9_ram
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the read controller.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo9_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer, followed by Gray-to-binary decode.
// Assumes: the source changes at most one bit per source clock.
module fifo9_ptr_sync #(
    parameter int W = 9
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    // Two-stage capture into the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    // Each binary bit is the XOR of all Gray bits at or above it.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(s2 >> i);
        end
    end
endmodule

// File: rtl/fifo9_wr_ctl.sv
`timescale 1ns/1ps
// Write-side control: role of the dual-purpose pin, write pointer, full and
// almost-full flags, the offset registers and the load rotation.
// Assumes: rptr_bin_s is already synchronized to wr_clk; offsets change only
// while traffic is idle, so the read side may use them directly.
module fifo9_wr_ctl
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int OFS_W = AW
)(
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic [BYTE_W-1:0] ofs_byte,
    input  logic [AW:0]       rptr_bin_s,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [AW:0]       wptr_gray,
    output logic              full,
    output logic              almost_full,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs
);
    localparam logic [AW:0]      FULL_CNT   = (AW+1)'(DEPTH);
    localparam logic [OFS_W-1:0] OFS_PRESET = OFS_W'(7);

    logic        ld_mode;
    logic        ld_act, wr_try, data_wr, ofs_wr;
    logic [AW:0] wbin, wbin_nxt, wr_count, free_cnt;
    logic [15:0] ae_wide, af_wide;
    ofs_step_e   step;

    assign ld_act   = ld_mode && !wr_en2_ld;
    assign wr_try   = !wr_en1_n && wr_en2_ld;
    assign ofs_wr   = ld_act && !wr_en1_n;
    assign wr_count = wbin - rptr_bin_s;
    assign free_cnt = FULL_CNT - wr_count;
    assign full        = (wr_count == FULL_CNT);
    assign almost_full = (free_cnt <= {1'b0, af_ofs});
    assign data_wr  = wr_try && !full;
    assign wbin_nxt = wbin + 1'b1;
    assign mem_we    = data_wr;
    assign mem_waddr = wbin[AW-1:0];
    assign ae_wide  = 16'(ae_ofs);
    assign af_wide  = 16'(af_ofs);

    // Latch the pin's role while reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ld_mode <= !wr_en2_ld;
        end
    end

    // Advance binary and Gray write pointers on each accepted word.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin      <= '0;
            wptr_gray <= '0;
        end else if (data_wr) begin
            wbin      <= wbin_nxt;
            wptr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Load offset bytes in rotation, masking bits beyond the kept width.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            step   <= STEP_AE_LO;
            ae_ofs <= OFS_PRESET;
            af_ofs <= OFS_PRESET;
        end else if (ofs_wr) begin
            unique case (step)
                STEP_AE_LO: ae_ofs <= OFS_W'({ae_wide[15:8], ofs_byte});
                STEP_AE_HI: ae_ofs <= OFS_W'({ofs_byte, ae_wide[7:0]});
                STEP_AF_LO: af_ofs <= OFS_W'({af_wide[15:8], ofs_byte});
                STEP_AF_HI: af_ofs <= OFS_W'({ofs_byte, af_wide[7:0]});
            endcase
            step <= next_step(step);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_count <= FULL_CNT); // R3
    AST_FULL_DROPS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_try) |=> $stable(wbin)); // R3
    AST_LOAD_NO_PUSH: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ld_act |=> $stable(wbin)); // R8
    AST_STEP_WRAPS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ofs_wr |=> (step == next_step($past(step)))); // R6
endmodule

// File: rtl/fifo9_rd_ctl.sv
`timescale 1ns/1ps
// Read-side control: read pointer, empty and almost-empty flags, the output
// register and the offset readback rotation.
// Assumes: wptr_bin_s is synchronized to rd_clk; the load pin is stable around
// rd_clk edges; offsets are quasi-static configuration.
module fifo9_rd_ctl
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int OFS_W = AW
)(
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              ld_pin,
    input  logic [AW:0]       wptr_bin_s,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [AW-1:0]     mem_raddr,
    output logic [AW:0]       rptr_gray,
    output logic [WORD_W-1:0] dout,
    output logic              empty,
    output logic              almost_empty
);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic              ld_mode;
    logic              ld_act, rd_req, data_rd, rb_rd;
    logic [AW:0]       rbin, rbin_nxt, rd_count;
    logic [15:0]       ae_wide, af_wide;
    logic [BYTE_W-1:0] rb_byte;
    ofs_step_e         rb_step;

    assign ld_act   = ld_mode && !ld_pin;
    assign rd_req   = !rd_en1_n && !rd_en2_n;
    assign rd_count = wptr_bin_s - rbin;
    assign empty        = (rd_count == '0);
    assign almost_empty = (rd_count <= {1'b0, ae_ofs});
    assign data_rd  = rd_req && !ld_act && !empty;
    assign rb_rd    = rd_req && ld_act;
    assign rbin_nxt = rbin + 1'b1;
    assign mem_raddr = rbin[AW-1:0];
    assign ae_wide  = 16'(ae_ofs);
    assign af_wide  = 16'(af_ofs);

    // Latch the pin's role while reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            ld_mode <= !ld_pin;
        end
    end

    // Pick the offset byte for the current readback step.
    always_comb begin
        unique case (rb_step)
            STEP_AE_LO: rb_byte = ae_wide[7:0];
            STEP_AE_HI: rb_byte = ae_wide[15:8];
            STEP_AF_LO: rb_byte = af_wide[7:0];
            STEP_AF_HI: rb_byte = af_wide[15:8];
        endcase
    end

    // Advance binary and Gray read pointers on each delivered word.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            rptr_gray <= '0;
        end else if (data_rd) begin
            rbin      <= rbin_nxt;
            rptr_gray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Load the output register with a data word or an offset byte.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            dout    <= '0;
            rb_step <= STEP_AE_LO;
        end else if (data_rd) begin
            dout <= mem_rdata;
        end else if (rb_rd) begin
            dout    <= {1'b0, rb_byte};
            rb_step <= next_step(rb_step);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_count <= FULL_CNT); // R3
    AST_EMPTY_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_req && empty && !ld_act) |=> ($stable(dout) && $stable(rbin))); // R4
    AST_LOAD_NO_POP: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ld_act |=> $stable(rbin)); // R8
    AST_RB_TOP_ZERO: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rb_rd |=> (dout[8] == 1'b0)); // R7
endmodule

// File: rtl/sync_fifo9_pgm.sv
`timescale 1ns/1ps
// Top: dual-clock 9-bit FIFO whose threshold offsets are loaded and read back
// over the data buses. Connects storage, both controllers and the two pointer
// synchronizers.
// Assumes: DEPTH is a power of two from 256 to 8192.
module sync_fifo9_pgm
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 256
)(
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    output logic [WORD_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic [AW:0]       wptr_gray, rptr_gray, wptr_bin_s, rptr_bin_s;
    logic [AW-1:0]     ae_ofs, af_ofs;

    fifo9_ram #(.DEPTH(DEPTH)) u_ram (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (din),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    fifo9_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en1_n    (wr_en1_n),
        .wr_en2_ld   (wr_en2_ld),
        .ofs_byte    (din[BYTE_W-1:0]),
        .rptr_bin_s  (rptr_bin_s),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .wptr_gray   (wptr_gray),
        .full        (full),
        .almost_full (almost_full),
        .ae_ofs      (ae_ofs),
        .af_ofs      (af_ofs)
    );

    fifo9_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .rd_en1_n     (rd_en1_n),
        .rd_en2_n     (rd_en2_n),
        .ld_pin       (wr_en2_ld),
        .wptr_bin_s   (wptr_bin_s),
        .mem_rdata    (mem_rdata),
        .ae_ofs       (ae_ofs),
        .af_ofs       (af_ofs),
        .mem_raddr    (mem_raddr),
        .rptr_gray    (rptr_gray),
        .dout         (dout),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    fifo9_ptr_sync #(.W(AW+1)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wptr_gray),
        .bin_out (wptr_bin_s)
    );

    fifo9_ptr_sync #(.W(AW+1)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rptr_gray),
        .bin_out (rptr_bin_s)
    );
endmodule

// File: tb/sync_fifo9_pgm_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random push/pop bursts, checked
// against a queue model and an offset-register model.
module sync_fifo9_pgm_bench;
    localparam int DEPTH   = 512;
    localparam int OW      = $clog2(DEPTH);
    localparam int HI_MASK = ((1 << OW) - 1) >> 8;

    logic       wr_clk, rd_clk, rst_n;
    logic [8:0] din, dout;
    logic       wr_en1_n, wr_en2_ld, rd_en1_n, rd_en2_n;
    logic       empty, full, almost_empty, almost_full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [8:0]  q[$];
    logic [15:0] m_ae, m_af;
    int          wstep, rstep;
    logic [8:0]  last_dout;

    sync_fifo9_pgm #(.DEPTH(DEPTH)) u_sync_fifo9_pgm (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
        .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .dout(dout),
        .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    initial begin
        wr_clk = 0;
        forever #2 wr_clk = ~wr_clk;
    end
    initial begin
        rd_clk = 0;
        #1;
        forever #2 rd_clk = ~rd_clk;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rb_byte(input int s);
        case (s)
            0: return m_ae[7:0];
            1: return m_ae[15:8];
            2: return m_af[7:0];
            default: return m_af[15:8];
        endcase
    endfunction

    task automatic settle();
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic chk_flags(input string tag);
        int c;
        settle();
        c = q.size();
        chk({tag, " empty"}, 32'(empty), 32'(c == 0));
        chk({tag, " full"}, 32'(full), 32'(c == DEPTH));
        chk({tag, " almost_empty"}, 32'(almost_empty), 32'(c <= int'(m_ae)));
        chk({tag, " almost_full"}, 32'(almost_full), 32'((DEPTH - c) <= int'(m_af)));
    endtask

    task automatic do_reset(input bit load_mode);
        @(negedge wr_clk);
        wr_en2_ld = load_mode ? 1'b0 : 1'b1;
        rst_n = 0;
        repeat (5) @(negedge wr_clk);
        rst_n = 1;
        q.delete();
        m_ae = 16'd7; m_af = 16'd7;
        wstep = 0; rstep = 0;
        last_dout = '0;
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wr_clk);
        wr_en1_n = 0; din = d;
        @(negedge wr_clk);
        wr_en1_n = 1;
        if (q.size() < DEPTH) q.push_back(d);
    endtask

    task automatic pop_check(input string tag);
        logic [8:0] exp;
        @(negedge rd_clk);
        rd_en1_n = 0; rd_en2_n = 0;
        @(negedge rd_clk);
        rd_en1_n = 1; rd_en2_n = 1;
        if (q.size() > 0) exp = q.pop_front();
        else exp = last_dout;
        chk(tag, 32'(dout), 32'(exp));
        last_dout = exp;
    endtask

    task automatic ofs_write(input logic [7:0] b);
        @(negedge wr_clk);
        wr_en1_n = 0; din = {1'b0, b};
        @(negedge wr_clk);
        wr_en1_n = 1;
        case (wstep)
            0: m_ae = {m_ae[15:8], b};
            1: m_ae = {8'(b & HI_MASK), m_ae[7:0]};
            2: m_af = {m_af[15:8], b};
            default: m_af = {8'(b & HI_MASK), m_af[7:0]};
        endcase
        wstep = (wstep + 1) % 4;
    endtask

    task automatic rb_check(input string tag);
        logic [8:0] exp;
        @(negedge rd_clk);
        rd_en1_n = 0; rd_en2_n = 0;
        @(negedge rd_clk);
        rd_en1_n = 1; rd_en2_n = 1;
        exp = {1'b0, rb_byte(rstep)};
        rstep = (rstep + 1) % 4;
        chk(tag, 32'(dout), 32'(exp));
        last_dout = exp;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        rst_n = 0; din = '0; wr_en1_n = 1; wr_en2_ld = 1; rd_en1_n = 1; rd_en2_n = 1;

        // R1: reset state, normal mode
        do_reset(1'b0);
        @(negedge wr_clk);
        chk("R1 dout", 32'(dout), 32'h0);
        chk("R1 empty", 32'(empty), 32'h1);
        chk("R1 full", 32'(full), 32'h0);
        chk("R1 almost_empty", 32'(almost_empty), 32'h1);
        chk("R1 almost_full", 32'(almost_full), 32'h0);

        // R5: second write enable low blocks writes
        @(negedge wr_clk);
        wr_en2_ld = 0; wr_en1_n = 0; din = 9'h1A5;
        repeat (4) @(negedge wr_clk);
        wr_en1_n = 1; wr_en2_ld = 1;
        settle();
        chk("R5 no write with enable2 low", 32'(empty), 32'h1);

        // R2: basic ordering
        for (int i = 0; i < 5; i++) push(9'(9'h100 + i * 3));
        chk_flags("R9 small count");
        for (int i = 0; i < 5; i++) pop_check("R2 order");
        settle();

        // R4: read while empty holds dout
        pop_check("R4 empty read");
        pop_check("R4 empty read");

        // R3/R9: fill with boundary checks on almost-full
        for (int i = 0; i < DEPTH - 8; i++) push(9'($urandom));
        chk_flags("R9 af boundary below");
        push(9'($urandom));
        chk_flags("R9 af boundary at");
        for (int i = 0; i < 7 + 2; i++) push(9'($urandom));
        chk_flags("R3 full");
        for (int i = 0; i < DEPTH - 8; i++) pop_check("R3 order after full");
        chk_flags("R9 ae boundary above");
        pop_check("R3 order after full");
        chk_flags("R9 ae boundary at");
        for (int i = 0; i < 7; i++) pop_check("R3 order after full");
        chk_flags("R2 drained");
        pop_check("R4 read after drain");

        // R9/R7: load mode, preset readback
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) rb_check("R9 preset readback");

        // R6/R7/R10: load and read back, high bits masked
        ofs_write(8'h10); ofs_write(8'hFF); ofs_write(8'h20); ofs_write(8'h00);
        for (int i = 0; i < 4; i++) rb_check("R10 masked readback");
        // R6: rotation wraps
        ofs_write(8'h03); ofs_write(8'h00); ofs_write(8'h05); ofs_write(8'h00);
        for (int i = 0; i < 4; i++) rb_check("R6 wrapped rotation");
        chk("R7 ae value", 32'(m_ae), 32'd3);
        @(negedge wr_clk);
        wr_en2_ld = 1;
        chk_flags("R8 empty after loads");

        // R8: load asserted leaves data alone
        for (int i = 0; i < 4; i++) push(9'(9'h0C0 + i));
        settle();
        @(negedge wr_clk);
        wr_en2_ld = 0;
        ofs_write(8'h03); ofs_write(8'h00);
        rb_check("R7 readback with data held");
        rb_check("R7 readback with data held");
        @(negedge wr_clk);
        wr_en2_ld = 1;
        chk_flags("R8 flags unchanged");
        for (int i = 0; i < 4; i++) pop_check("R8 data intact");

        // Random bursts against loaded thresholds
        for (int r = 0; r < 40; r++) begin
            int len;
            len = 1 + int'($urandom % 12);
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < len; k++) push(9'($urandom));
            end else begin
                for (int k = 0; k < len; k++) pop_check("R2 random order");
            end
            chk_flags("R9 random flags");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule